// File: doc/BRIEF.md
# PCIe Root-Port Client Register Block

This block is the small control and status register file that sits next to a PCIe root-port core on an APB bus. Software uses it to put the core into root-complex mode, to start link training, to select the enhanced training-control mode, to mask or unmask the four legacy INTx lines, and to poll the training state. Every writable register uses a half-word write-mask: the upper 16 bits of the write data say which of the lower 16 bits may change. A single write can therefore set or clear any group of control bits without a read-modify-write sequence.

The four INTx inputs are combined into one level-sensitive interrupt that is high while any unmasked line is active. Training state and both link-up flags arrive from the core's clock domain and pass through a synchronizer. The block then raises a link-up flag only when both layers report up and the state code is the one for the active link state.

Top module: `pcie_client_csr`

## Requirements
- R1: On an APB write to a writable register, write-data bit i+16 enables the update of stored bit i (i = 0..15) to write-data bit i; stored bits whose enable is 0 keep their value.
- R2: The general control register is at offset 0x000. Stored bit 6 drives `rc_mode_o`. `ltssm_en_o` is 1 only while stored bits 2 and 3 are both 1.
- R3: The hot-reset control register is at offset 0x180, and its stored bit 4 drives `enh_ltssm_o`.
- R4: The INTx mask register is at offset 0x01C, with bits 3..0 belonging to INTA..INTD. A stored 1 masks the line and a stored 0 unmasks it.
- R5: A read of offset 0x008 returns the present level of `intx_i` in bits 3..0. `irq_o` is 1 in the cycle after a clock edge at which some `intx_i` bit is 1 and its mask bit, including a mask write taking effect at that same edge, is 0. Otherwise it is 0.
- R6: A read of offset 0x300 returns the synchronized training state in bits 5..0, the physical-layer up flag in bit 16 and the data-link up flag in bit 17. An input change is visible after two clock edges.
- R7: `link_up_o` is 1 only when the synchronized physical-layer and data-link flags are both 1 and the synchronized state equals 0x11.
- R8: After reset, every stored bit is 0, and so are `rc_mode_o`, `ltssm_en_o`, `enh_ltssm_o`, `irq_o` and `link_up_o`. Reads of writable registers return 0 in bits 31..16.
- R9: The debug register at offset 0x104 holds 16 write-masked bits that read back in bits 15..0.
- R10: A read of an unmapped offset returns 0. A write to an unmapped offset changes no stored bit and no output.
- R11: `pready_o` is always 1 and `pslverr_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte offset |
| pwdata | input | 32 | APB write data: enables in 31..16, values in 15..0 |
| prdata | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, held high |
| pslverr_o | output | 1 | APB error, held low |
| intx_i | input | INTX_N | Legacy INTA..INTD levels |
| irq_o | output | 1 | Combined legacy interrupt |
| rc_mode_o | output | 1 | Root-complex mode select to the core |
| ltssm_en_o | output | 1 | Link-training enable to the core |
| enh_ltssm_o | output | 1 | Enhanced training-control mode to the core |
| ltssm_state_i | input | LTSSM_W | Training state code from the core |
| phy_up_i | input | 1 | Physical-layer link-up from the core |
| dll_up_i | input | 1 | Data-link-layer link-up from the core |
| link_up_o | output | 1 | Qualified link-up flag |

## Verification
A mask-register write and a change on the INTx inputs can land at the same clock edge. The interrupt must then be judged against the new mask, not the stored one. The bench provokes this by changing `intx_i` in the access phase of a mask write. In one case the write masks the line that is just rising, and in the other it unmasks a line that is already high. In the cycle after that edge it checks `irq_o` against the mask value the write produced.

// File: rtl/pcie_client_pkg.sv
package pcie_client_pkg;

    localparam int unsigned HALF_W = 16;

    // Register offsets (byte addresses)
    localparam logic [31:0] OFS_GEN_CTRL  = 32'h0000_0000;
    localparam logic [31:0] OFS_INTX_STAT = 32'h0000_0008;
    localparam logic [31:0] OFS_INTX_MASK = 32'h0000_001C;
    localparam logic [31:0] OFS_DEBUG     = 32'h0000_0104;
    localparam logic [31:0] OFS_HOT_RST   = 32'h0000_0180;
    localparam logic [31:0] OFS_LINK_STAT = 32'h0000_0300;

    // Bit positions the core side decodes
    localparam int unsigned GEN_RC_BIT    = 6;
    localparam int unsigned GEN_TRAIN_LO  = 2;
    localparam int unsigned GEN_TRAIN_HI  = 3;
    localparam int unsigned HOT_ENH_BIT   = 4;
    localparam int unsigned LINK_PHY_BIT  = 16;

    typedef struct packed {
        logic [HALF_W-1:0] gen;
        logic [HALF_W-1:0] hot;
        logic [HALF_W-1:0] dbg;
        logic [HALF_W-1:0] msk;
    } ctl_regs_t;

    function automatic logic [HALF_W-1:0] masked_merge(
        input logic [HALF_W-1:0] old_v,
        input logic [HALF_W-1:0] en_v,
        input logic [HALF_W-1:0] new_v
    );
        return (old_v & ~en_v) | (new_v & en_v);
    endfunction

endpackage

// File: rtl/pcie_client_link_sync.sv
module pcie_client_link_sync #(
    parameter int unsigned LTSSM_W = 6,
    parameter int unsigned STAGES  = 2,
    parameter logic [LTSSM_W-1:0] L0_CODE = 6'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LTSSM_W-1:0] state_i,
    input  logic               phy_up_i,
    input  logic               dll_up_i,
    output logic [LTSSM_W-1:0] state_s_o,
    output logic               phy_up_s_o,
    output logic               dll_up_s_o,
    output logic               link_up_o
);
    localparam int unsigned WORD_W = LTSSM_W + 2;

    logic [STAGES-1:0][WORD_W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d    = stage_q;
        stage_d[0] = {dll_up_i, phy_up_i, state_i};
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign state_s_o  = stage_q[STAGES-1][LTSSM_W-1:0];
    assign phy_up_s_o = stage_q[STAGES-1][LTSSM_W];
    assign dll_up_s_o = stage_q[STAGES-1][LTSSM_W+1];
    assign link_up_o  = phy_up_s_o && dll_up_s_o && (state_s_o == L0_CODE);

endmodule

// File: rtl/pcie_client_intx_agg.sv
module pcie_client_intx_agg #(
    parameter int unsigned INTX_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTX_N-1:0] intx_i,
    input  logic [INTX_N-1:0] mask_nxt_i,
    output logic              irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(intx_i & ~mask_nxt_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/pcie_client_regs.sv
module pcie_client_regs
    import pcie_client_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned INTX_N  = 4,
    parameter int unsigned LTSSM_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    input  logic [INTX_N-1:0]  intx_i,
    input  logic [LTSSM_W-1:0] state_s_i,
    input  logic               phy_up_s_i,
    input  logic               dll_up_s_i,
    output ctl_regs_t          regs_o,
    output logic [INTX_N-1:0]  mask_nxt_o
);
    ctl_regs_t regs_d, regs_q;

    logic [31:0]        addr_ext;
    logic               wr_en;
    logic [HALF_W-1:0]  wr_mask;
    logic [HALF_W-1:0]  wr_val;

    assign addr_ext = 32'(paddr);
    assign wr_en    = psel && penable && pwrite;
    assign wr_mask  = pwdata[31:16];
    assign wr_val   = pwdata[15:0];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (addr_ext)
                OFS_GEN_CTRL:  regs_d.gen = masked_merge(regs_q.gen, wr_mask, wr_val);
                OFS_HOT_RST:   regs_d.hot = masked_merge(regs_q.hot, wr_mask, wr_val);
                OFS_DEBUG:     regs_d.dbg = masked_merge(regs_q.dbg, wr_mask, wr_val);
                OFS_INTX_MASK: regs_d.msk = masked_merge(regs_q.msk, wr_mask, wr_val);
                default:       regs_d = regs_q;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (addr_ext)
                OFS_GEN_CTRL:  prdata = 32'(regs_q.gen);
                OFS_HOT_RST:   prdata = 32'(regs_q.hot);
                OFS_DEBUG:     prdata = 32'(regs_q.dbg);
                OFS_INTX_MASK: prdata = 32'(regs_q.msk);
                OFS_INTX_STAT: prdata = 32'(intx_i);
                OFS_LINK_STAT: prdata = (32'({dll_up_s_i, phy_up_s_i}) << LINK_PHY_BIT)
                                      | 32'(state_s_i);
                default:       prdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o     = regs_q;
    assign mask_nxt_o = regs_d.msk[INTX_N-1:0];

endmodule

// File: rtl/pcie_client_csr.sv
module pcie_client_csr
    import pcie_client_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned INTX_N      = 4,
    parameter int unsigned LTSSM_W     = 6,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [LTSSM_W-1:0] L0_CODE = 6'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready_o,
    output logic               pslverr_o,
    input  logic [INTX_N-1:0]  intx_i,
    output logic               irq_o,
    output logic               rc_mode_o,
    output logic               ltssm_en_o,
    output logic               enh_ltssm_o,
    input  logic [LTSSM_W-1:0] ltssm_state_i,
    input  logic               phy_up_i,
    input  logic               dll_up_i,
    output logic               link_up_o
);
    ctl_regs_t          regs;
    logic [INTX_N-1:0]  mask_nxt;
    logic [LTSSM_W-1:0] state_s;
    logic               phy_up_s;
    logic               dll_up_s;

    pcie_client_link_sync #(
        .LTSSM_W (LTSSM_W),
        .STAGES  (SYNC_STAGES),
        .L0_CODE (L0_CODE)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (ltssm_state_i),
        .phy_up_i   (phy_up_i),
        .dll_up_i   (dll_up_i),
        .state_s_o  (state_s),
        .phy_up_s_o (phy_up_s),
        .dll_up_s_o (dll_up_s),
        .link_up_o  (link_up_o)
    );

    pcie_client_regs #(
        .ADDR_W  (ADDR_W),
        .INTX_N  (INTX_N),
        .LTSSM_W (LTSSM_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .intx_i     (intx_i),
        .state_s_i  (state_s),
        .phy_up_s_i (phy_up_s),
        .dll_up_s_i (dll_up_s),
        .regs_o     (regs),
        .mask_nxt_o (mask_nxt)
    );

    pcie_client_intx_agg #(
        .INTX_N (INTX_N)
    ) u_intx (
        .clk        (clk),
        .rst_n      (rst_n),
        .intx_i     (intx_i),
        .mask_nxt_i (mask_nxt),
        .irq_o      (irq_o)
    );

    assign rc_mode_o   = regs.gen[GEN_RC_BIT];
    assign ltssm_en_o  = regs.gen[GEN_TRAIN_LO] && regs.gen[GEN_TRAIN_HI];
    assign enh_ltssm_o = regs.hot[HOT_ENH_BIT];
    assign pready_o    = 1'b1;
    assign pslverr_o   = 1'b0;

endmodule

// File: rtl/pcie_client_csr_chk.sv
module pcie_client_csr_chk
    import pcie_client_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned INTX_N  = 4,
    parameter int unsigned LTSSM_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        pwdata,
    input logic [31:0]        prdata,
    input logic [INTX_N-1:0]  intx_i,
    input logic               irq_o,
    input logic               rc_mode_o,
    input logic               enh_ltssm_o,
    input logic               phy_up_i,
    input logic               dll_up_i,
    input logic               link_up_o
);
    logic [31:0] a;
    logic        wr;
    logic        mapped;

    assign a  = 32'(paddr);
    assign wr = psel && penable && pwrite;
    assign mapped = (a == OFS_GEN_CTRL) || (a == OFS_INTX_STAT) || (a == OFS_INTX_MASK)
                 || (a == OFS_DEBUG) || (a == OFS_HOT_RST) || (a == OFS_LINK_STAT);

    // R2: root-complex select moves only on a general-control write enabling bit 6
    a_r2_rc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && a == OFS_GEN_CTRL && pwdata[22]) |=> $stable(rc_mode_o));

    // R3: enhanced mode moves only on a hot-reset write enabling bit 4
    a_r3_enh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && a == OFS_HOT_RST && pwdata[20]) |=> $stable(enh_ltssm_o));

    // R5: interrupt needs an active INTx line at the previous edge
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|intx_i));

    // R7: qualified link-up needs both layer flags two edges earlier (default sync depth)
    a_r7_link_cause: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |-> $past(phy_up_i && dll_up_i, 2));

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && !mapped) |-> (prdata == 32'h0));

endmodule

bind pcie_client_csr pcie_client_csr_chk #(
    .ADDR_W  (ADDR_W),
    .INTX_N  (INTX_N),
    .LTSSM_W (LTSSM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .prdata      (prdata),
    .intx_i      (intx_i),
    .irq_o       (irq_o),
    .rc_mode_o   (rc_mode_o),
    .enh_ltssm_o (enh_ltssm_o),
    .phy_up_i    (phy_up_i),
    .dll_up_i    (dll_up_i),
    .link_up_o   (link_up_o)
);

// File: tb/pcie_client_csr_test.sv
module pcie_client_csr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready_o, pslverr_o;
    logic [3:0]  intx_i = '0;
    logic        irq_o, rc_mode_o, ltssm_en_o, enh_ltssm_o, link_up_o;
    logic [5:0]  ltssm_state_i = '0;
    logic        phy_up_i = 1'b0;
    logic        dll_up_i = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcie_client_csr uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready_o(pready_o),
        .pslverr_o(pslverr_o), .intx_i(intx_i), .irq_o(irq_o), .rc_mode_o(rc_mode_o),
        .ltssm_en_o(ltssm_en_o), .enh_ltssm_o(enh_ltssm_o), .ltssm_state_i(ltssm_state_i),
        .phy_up_i(phy_up_i), .dll_up_i(dll_up_i), .link_up_o(link_up_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1 check("R11 pready", 32'(pready_o), 32'h1);
        check("R11 pslverr", 32'(pslverr_o), 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R8 rc_mode", 32'(rc_mode_o), 0);
        check("R8 ltssm_en", 32'(ltssm_en_o), 0);
        check("R8 enh", 32'(enh_ltssm_o), 0);
        check("R8 irq", 32'(irq_o), 0);
        check("R8 link_up", 32'(link_up_o), 0);
        apb_read(12'h000, r); check("R8 gen", r, 0);
        apb_read(12'h01C, r); check("R8 mask", r, 0);
        apb_read(12'h180, r); check("R8 hot", r, 0);
    endtask

    task automatic t_gen_ctrl();
        logic [31:0] r;
        apb_write(12'h000, 32'h004C_004C);
        check("R2 rc_mode set", 32'(rc_mode_o), 1);
        check("R2 ltssm_en set", 32'(ltssm_en_o), 1);
        apb_read(12'h000, r); check("R8 gen upper zero", r, 32'h0000_004C);
        apb_write(12'h000, 32'h0008_0000);
        apb_read(12'h000, r); check("R1 only bit3 cleared", r, 32'h0000_0044);
        check("R2 ltssm_en needs both bits", 32'(ltssm_en_o), 0);
        check("R2 rc_mode kept", 32'(rc_mode_o), 1);
        apb_write(12'h000, 32'h0000_FFFF);
        apb_read(12'h000, r); check("R1 zero enables no change", r, 32'h0000_0044);
        apb_write(12'h000, 32'h000C_000C);
        check("R2 ltssm_en again", 32'(ltssm_en_o), 1);
        apb_write(12'h000, 32'hFFFF_0000);
        apb_read(12'h000, r); check("R1 clear all", r, 0);
        check("R2 rc_mode cleared", 32'(rc_mode_o), 0);
    endtask

    task automatic t_hot();
        logic [31:0] r;
        apb_write(12'h180, 32'h0010_0010);
        check("R3 enh set", 32'(enh_ltssm_o), 1);
        apb_read(12'h180, r); check("R3 hot readback", r, 32'h0000_0010);
        apb_write(12'h180, 32'h0001_0001);
        check("R3 enh kept", 32'(enh_ltssm_o), 1);
        apb_read(12'h180, r); check("R1 hot merge", r, 32'h0000_0011);
    endtask

    task automatic t_debug();
        logic [31:0] r;
        apb_write(12'h104, 32'h00FF_A5A5);
        apb_read(12'h104, r); check("R9 debug low byte", r, 32'h0000_00A5);
        apb_write(12'h104, 32'hFF00_3C3C);
        apb_read(12'h104, r); check("R9 debug merge", r, 32'h0000_3CA5);
    endtask

    task automatic t_intx();
        logic [31:0] r;
        @(negedge clk); intx_i = 4'b0101;
        @(negedge clk); check("R5 irq unmasked", 32'(irq_o), 1);
        apb_read(12'h008, r); check("R5 status level", r, 32'h5);
        apb_write(12'h01C, 32'h000F_0005);
        check("R4 masked lines", 32'(irq_o), 0);
        @(negedge clk); intx_i = 4'b0010;
        @(negedge clk); check("R4 INTB unmasked", 32'(irq_o), 1);
        apb_write(12'h01C, 32'h0002_0002);
        check("R4 INTB masked", 32'(irq_o), 0);
        apb_read(12'h01C, r); check("R4 mask readback", r, 32'h7);
        apb_read(12'h008, r); check("R5 status follows level", r, 32'h2);
    endtask

    task automatic t_same_cycle();
        // mask INTD in the same edge INTD rises
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h01C; pwdata = 32'h0008_0008;
        @(negedge clk); penable = 1'b1; intx_i = 4'b1000;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R5 same-edge mask wins", 32'(irq_o), 0);
        // unmask INTD while it is high
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h01C; pwdata = 32'h0008_0000;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R5 same-edge unmask", 32'(irq_o), 1);
        @(negedge clk); intx_i = 4'b0000;
        @(negedge clk); check("R5 irq drops", 32'(irq_o), 0);
    endtask

    task automatic t_link();
        logic [31:0] r;
        @(negedge clk); ltssm_state_i = 6'h11; phy_up_i = 1'b1; dll_up_i = 1'b1;
        @(negedge clk); check("R6 one edge not yet", 32'(link_up_o), 0);
        @(negedge clk); check("R7 link up", 32'(link_up_o), 1);
        apb_read(12'h300, r); check("R6 status layout", r, 32'h0003_0011);
        @(negedge clk); dll_up_i = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R7 needs data-link up", 32'(link_up_o), 0);
        apb_read(12'h300, r); check("R6 phy only", r, 32'h0001_0011);
        @(negedge clk); dll_up_i = 1'b1; ltssm_state_i = 6'h10;
        @(negedge clk); @(negedge clk);
        check("R7 needs state 0x11", 32'(link_up_o), 0);
        apb_read(12'h300, r); check("R6 other state", r, 32'h0003_0010);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        apb_write(12'h004, 32'hFFFF_FFFF);
        apb_write(12'h200, 32'hFFFF_FFFF);
        apb_read(12'h004, r); check("R10 unmapped read", r, 0);
        apb_read(12'h200, r); check("R10 unmapped read 2", r, 0);
        apb_read(12'h000, r); check("R10 gen untouched", r, 0);
        apb_read(12'h01C, r); check("R10 mask untouched", r, 32'h7);
        apb_read(12'h104, r); check("R10 debug untouched", r, 32'h3CA5);
        check("R10 rc_mode untouched", 32'(rc_mode_o), 0);
        check("R10 enh untouched", 32'(enh_ltssm_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gen_ctrl();
        t_hot();
        t_debug();
        t_intx();
        t_same_cycle();
        t_link();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule